// File: doc/BRIEF.md
# Exception priority masking unit

This block decides, once per clock, whether any pending exception may be activated. It combines three software-visible masks: a one-bit fault mask, a one-bit primask, and a 3-bit base priority threshold. These masks are applied to a vector of pending requests. Each request carries its own 3-bit programmable priority, where a smaller number means more urgent. A separate non-maskable request bypasses every mask.

The masks are reached through a small register port, selected by a 2-bit code. Both writes and reads are honoured only while the privilege input is high. The block filters the pending requests against the masks and picks the most urgent survivor. It registers the result as an activate strobe together with the winner's index and a flag marking a non-maskable win. The sequencing that follows activation is handled elsewhere.

The result port is a plain control output with no back-pressure. The strobe is valid for the single cycle in which it is high. The block re-evaluates on every clock, so a request that remains pending and unmasked produces a strobe on every cycle.

Top module: `exc_mask_unit`

## Requirements
- R1: After reset, all three masks read as zero through a privileged read, and `act_strobe`, `act_nmi` and `act_idx` are zero.
- R2: Register select codes are: 0 = fault mask, held in bit 0; 1 = primask, held in bit 0; 2 = base priority, held in bits 7:5; 3 = no register, reads zero and ignores writes. All other bits read as zero whatever was written to them.
- R3: A write with `priv` low leaves all three masks unchanged.
- R4: A read with `priv` low returns zero on `reg_rdata`.
- R5: While the fault mask is 1, no programmable request is activated. A non-maskable request is still activated.
- R6: While primask is 1, no programmable request is activated.
- R7: A base priority of zero masks nothing.
- R8: A nonzero base priority N masks every programmable request whose priority is N or greater. For example, N=3 blocks priorities 3 to 7, and N=7 blocks only priority 7.
- R9: `nmi_req` is never masked. It always wins, giving `act_nmi`=1 and `act_idx`=0.
- R10: Among unmasked pending requests, the lowest numeric priority wins. Equal priorities go to the lowest index.
- R11: Outputs are registered. Inputs present before a rising edge are reflected after that edge. `act_strobe` is high only for cycles with a winner; `act_idx` names a request that was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv | input | 1 | High when the current access is privileged |
| reg_wr_en | input | 1 | Register write enable |
| reg_sel | input | 2 | Register select code (see R2) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_sel` |
| req_pend | input | NREQ (8) | Pending programmable requests, one bit per request |
| req_prio | input | NREQ*3 (24) | Priority of request i in bits [3i+2:3i] |
| nmi_req | input | 1 | Non-maskable request |
| act_strobe | output | 1 | A request is activated in this cycle |
| act_nmi | output | 1 | The activated request is the non-maskable one |
| act_idx | output | 3 | Index of the activated programmable request |

## Verification
The assertions assume that `priv`, the request vector and the priorities are settled before each rising edge. They also assume that `req_prio` is only meaningful for bits set in `req_pend`. The index and threshold checks rely on `act_idx` never pointing past the last request. The bench drives every input on the falling edge and holds it for a full cycle. It only ever raises pending bits whose priorities it has set explicitly, so the stimulus stays inside these assumptions.

// File: rtl/exc_mask_pkg.sv
package exc_mask_pkg;
  localparam int PRIO_W   = 3;
  localparam int REG_W    = 32;
  localparam int BASE_LSB = 5;

  typedef enum logic [1:0] {
    SEL_FAULT = 2'd0,
    SEL_PRI   = 2'd1,
    SEL_BASE  = 2'd2,
    SEL_NONE  = 2'd3
  } mask_sel_e;
endpackage

// File: rtl/exc_mask_regs.sv
module exc_mask_regs
  import exc_mask_pkg::*;
#(
  parameter int PW = PRIO_W,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          priv,
  input  logic          wr_en,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          fault_q,
  output logic          pri_q,
  output logic [PW-1:0] base_q
);
  localparam int BASE_MSB = BASE_LSB + PW - 1;

  mask_sel_e sel_e;
  assign sel_e = mask_sel_e'(sel);

  // Only bit 0 and the base field are ever consumed.
  logic unused_wbits;
  assign unused_wbits = ^{wdata[DW-1:BASE_MSB+1], wdata[BASE_LSB-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      pri_q   <= 1'b0;
      base_q  <= '0;
    end else if (priv && wr_en) begin
      case (sel_e)
        SEL_FAULT: fault_q <= wdata[0];
        SEL_PRI:   pri_q   <= wdata[0];
        SEL_BASE:  base_q  <= wdata[BASE_MSB:BASE_LSB];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (priv) begin
      case (sel_e)
        SEL_FAULT: rdata[0] = fault_q;
        SEL_PRI:   rdata[0] = pri_q;
        SEL_BASE:  rdata[BASE_MSB:BASE_LSB] = base_q;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/exc_mask_filter.sv
module exc_mask_filter
  import exc_mask_pkg::*;
#(
  parameter int NREQ = 8,
  parameter int PW   = PRIO_W
) (
  input  logic [NREQ-1:0]    pend,
  input  logic [NREQ*PW-1:0] prio,
  input  logic               fault_q,
  input  logic               pri_q,
  input  logic [PW-1:0]      base_q,
  output logic [NREQ-1:0]    elig
);
  logic block_all;
  logic thresh_on;
  assign block_all = fault_q | pri_q;
  assign thresh_on = (base_q != '0);

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    logic [PW-1:0] lvl;
    logic          over;
    assign lvl     = prio[i*PW +: PW];
    assign over    = thresh_on && (lvl >= base_q);
    assign elig[i] = pend[i] & ~block_all & ~over;
  end
endmodule

// File: rtl/exc_prio_select.sv
module exc_prio_select
  import exc_mask_pkg::*;
#(
  parameter int NREQ = 8,
  parameter int PW   = PRIO_W,
  localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic [NREQ-1:0]    elig,
  input  logic [NREQ*PW-1:0] prio,
  output logic               found,
  output logic [IW-1:0]      win_idx
);
  logic [PW-1:0] best;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    best    = '1;
    for (int i = 0; i < NREQ; i++) begin
      // Strict compare keeps the lowest index on a tie.
      if (elig[i] && (!found || prio[i*PW +: PW] < best)) begin
        found   = 1'b1;
        win_idx = IW'(i);
        best    = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/exc_mask_unit.sv
module exc_mask_unit
  import exc_mask_pkg::*;
#(
  parameter int NREQ = 8,
  localparam int PW  = PRIO_W,
  localparam int DW  = REG_W,
  localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               priv,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_sel,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic [NREQ-1:0]    req_pend,
  input  logic [NREQ*PW-1:0] req_prio,
  input  logic               nmi_req,
  output logic               act_strobe,
  output logic               act_nmi,
  output logic [IW-1:0]      act_idx
);
  logic          fault_q;
  logic          pri_q;
  logic [PW-1:0] base_q;
  logic [NREQ-1:0] elig;
  logic          found;
  logic [IW-1:0] win_idx;

  exc_mask_regs #(.PW(PW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .priv    (priv),
    .wr_en   (reg_wr_en),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .fault_q (fault_q),
    .pri_q   (pri_q),
    .base_q  (base_q)
  );

  exc_mask_filter #(.NREQ(NREQ), .PW(PW)) u_filter (
    .pend    (req_pend),
    .prio    (req_prio),
    .fault_q (fault_q),
    .pri_q   (pri_q),
    .base_q  (base_q),
    .elig    (elig)
  );

  exc_prio_select #(.NREQ(NREQ), .PW(PW)) u_sel (
    .elig    (elig),
    .prio    (req_prio),
    .found   (found),
    .win_idx (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_strobe <= 1'b0;
      act_nmi    <= 1'b0;
      act_idx    <= '0;
    end else begin
      act_strobe <= nmi_req | found;
      act_nmi    <= nmi_req;
      act_idx    <= nmi_req ? '0 : win_idx;
    end
  end
endmodule

// File: rtl/exc_mask_chk.sv
module exc_mask_chk #(
  parameter int NREQ = 8,
  parameter int PW   = 3,
  parameter int DW   = 32,
  localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               priv,
  input logic               reg_wr_en,
  input logic [DW-1:0]      reg_rdata,
  input logic [NREQ-1:0]    req_pend,
  input logic [NREQ*PW-1:0] req_prio,
  input logic               nmi_req,
  input logic               act_strobe,
  input logic               act_nmi,
  input logic [IW-1:0]      act_idx,
  input logic               fault_q,
  input logic               pri_q,
  input logic [PW-1:0]      base_q
);
  logic               live;
  logic [NREQ-1:0]    pend_d;
  logic [NREQ*PW-1:0] prio_d;
  logic [PW-1:0]      base_d;
  logic [PW-1:0]      sel_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= 1'b0;
      pend_d <= '0;
      prio_d <= '0;
      base_d <= '0;
    end else begin
      live   <= 1'b1;
      pend_d <= req_pend;
      prio_d <= req_prio;
      base_d <= base_q;
    end
  end

  assign sel_lvl = prio_d[act_idx*PW +: PW];

  assert_nmi_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> (act_strobe && act_nmi && act_idx == '0));

  assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !nmi_req) |=> !act_strobe);

  assert_primask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_q && !nmi_req) |=> !act_strobe);

  assert_unpriv_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv && reg_wr_en) |=> ($stable(fault_q) && $stable(pri_q) && $stable(base_q)));

  assert_unpriv_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !priv |-> (reg_rdata == '0));

  assert_threshold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && act_strobe && !act_nmi && base_d != '0) |-> (sel_lvl < base_d));

  assert_pending_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (live && act_strobe && !act_nmi) |-> pend_d[act_idx]);
endmodule

bind exc_mask_unit exc_mask_chk #(.NREQ(NREQ), .PW(PW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .priv       (priv),
  .reg_wr_en  (reg_wr_en),
  .reg_rdata  (reg_rdata),
  .req_pend   (req_pend),
  .req_prio   (req_prio),
  .nmi_req    (nmi_req),
  .act_strobe (act_strobe),
  .act_nmi    (act_nmi),
  .act_idx    (act_idx),
  .fault_q    (fault_q),
  .pri_q      (pri_q),
  .base_q     (base_q)
);

// File: tb/test_exc_mask_unit.sv
`timescale 1ns/1ps
module test_exc_mask_unit;
  localparam int NREQ = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NREQ-1:0]   req_pend = '0;
  logic [NREQ*3-1:0] req_prio = '0;
  logic        nmi_req = 1'b0;
  logic        act_strobe;
  logic        act_nmi;
  logic [2:0]  act_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  exc_mask_unit #(.NREQ(NREQ)) i_exc_mask_unit (
    .clk(clk), .rst_n(rst_n), .priv(priv), .reg_wr_en(reg_wr_en),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_pend(req_pend), .req_prio(req_prio), .nmi_req(nmi_req),
    .act_strobe(act_strobe), .act_nmi(act_nmi), .act_idx(act_idx)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    priv = p; reg_sel = s; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; priv = 1'b1;
  endtask

  task automatic rd_check(input string tag, input logic p, input logic [1:0] s, input logic [31:0] exp);
    @(negedge clk);
    priv = p; reg_sel = s;
    #1;
    check32(tag, reg_rdata, exp);
    priv = 1'b1;
  endtask

  task automatic set_prio(input int idx, input logic [2:0] lvl);
    req_prio[idx*3 +: 3] = lvl;
  endtask

  // Apply requests at a falling edge, sample one full cycle later.
  task automatic act_check(input string tag, input logic [NREQ-1:0] pend, input logic nmi,
                           input logic e_stb, input logic e_nmi, input logic [2:0] e_idx);
    @(negedge clk);
    req_pend = pend; nmi_req = nmi;
    @(negedge clk);
    check32(tag, {29'd0, act_strobe, act_nmi, e_stb ? act_idx[0] : 1'b0},
                 {29'd0, e_stb, e_nmi, e_stb ? e_idx[0] : 1'b0});
    if (e_stb) check32({tag, " idx"}, {29'd0, act_idx}, {29'd0, e_idx});
    req_pend = '0; nmi_req = 1'b0;
  endtask

  task automatic t_reset;
    check32("R1 strobe after reset", {29'd0, act_strobe, act_nmi, 1'b0}, 32'd0);
    check32("R1 idx after reset", {29'd0, act_idx}, 32'd0);
    rd_check("R1 fault mask reset", 1'b1, 2'd0, 32'd0);
    rd_check("R1 primask reset", 1'b1, 2'd1, 32'd0);
    rd_check("R1 base reset", 1'b1, 2'd2, 32'd0);
  endtask

  task automatic t_layout;
    wr(1'b1, 2'd2, 32'hFFFF_FFFF);
    rd_check("R2 base field bits 7:5", 1'b1, 2'd2, 32'h0000_00E0);
    wr(1'b1, 2'd0, 32'hFFFF_FFFE);
    rd_check("R2 fault mask needs bit 0", 1'b1, 2'd0, 32'd0);
    wr(1'b1, 2'd0, 32'hFFFF_FFFF);
    rd_check("R2 fault mask bit 0 only", 1'b1, 2'd0, 32'd1);
    wr(1'b1, 2'd1, 32'h8000_0001);
    rd_check("R2 primask bit 0 only", 1'b1, 2'd1, 32'd1);
    wr(1'b1, 2'd3, 32'hFFFF_FFFF);
    rd_check("R2 code 3 reads zero", 1'b1, 2'd3, 32'd0);
    wr(1'b1, 2'd0, 32'd0);
    wr(1'b1, 2'd1, 32'd0);
    wr(1'b1, 2'd2, 32'd0);
    rd_check("R2 base cleared", 1'b1, 2'd2, 32'd0);
  endtask

  task automatic t_priv;
    wr(1'b0, 2'd2, 32'h0000_0060);
    rd_check("R3 unpriv base write ignored", 1'b1, 2'd2, 32'd0);
    wr(1'b0, 2'd0, 32'd1);
    rd_check("R3 unpriv fault write ignored", 1'b1, 2'd0, 32'd0);
    wr(1'b1, 2'd1, 32'd1);
    rd_check("R4 unpriv read of primask", 1'b0, 2'd1, 32'd0);
    rd_check("R4 priv read of primask", 1'b1, 2'd1, 32'd1);
    wr(1'b1, 2'd1, 32'd0);
  endtask

  task automatic t_arbitrate;
    req_prio = '0;
    set_prio(2, 3'd4); set_prio(5, 3'd1);
    act_check("R10 lowest level wins", 8'b0010_0100, 1'b0, 1'b1, 1'b0, 3'd5);
    set_prio(1, 3'd2); set_prio(3, 3'd2);
    act_check("R10 tie to lowest index", 8'b0000_1010, 1'b0, 1'b1, 1'b0, 3'd1);
    set_prio(7, 3'd7);
    act_check("R7 base zero passes level 7", 8'b1000_0000, 1'b0, 1'b1, 1'b0, 3'd7);
    act_check("R11 no request no strobe", 8'b0000_0000, 1'b0, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_base;
    req_prio = '0;
    wr(1'b1, 2'd2, 32'h0000_0060);   // threshold 3
    set_prio(0, 3'd3); set_prio(4, 3'd2);
    act_check("R8 N=3 passes level 2 only", 8'b0001_0001, 1'b0, 1'b1, 1'b0, 3'd4);
    set_prio(6, 3'd7);
    act_check("R8 N=3 blocks levels 3 and 7", 8'b0100_0001, 1'b0, 1'b0, 1'b0, 3'd0);
    wr(1'b1, 2'd2, 32'h0000_00E0);   // threshold 7
    set_prio(2, 3'd6);
    act_check("R8 N=7 passes level 6", 8'b0100_0100, 1'b0, 1'b1, 1'b0, 3'd2);
    act_check("R8 N=7 blocks level 7", 8'b0100_0000, 1'b0, 1'b0, 1'b0, 3'd0);
    wr(1'b1, 2'd2, 32'd0);
  endtask

  task automatic t_masks;
    req_prio = '0;
    set_prio(3, 3'd0);
    wr(1'b1, 2'd1, 32'd1);
    act_check("R6 primask blocks level 0", 8'b0000_1000, 1'b0, 1'b0, 1'b0, 3'd0);
    act_check("R9 nmi through primask", 8'b0000_1000, 1'b1, 1'b1, 1'b1, 3'd0);
    wr(1'b1, 2'd1, 32'd0);
    wr(1'b1, 2'd0, 32'd1);
    act_check("R5 fault mask blocks level 0", 8'b0000_1000, 1'b0, 1'b0, 1'b0, 3'd0);
    act_check("R5 nmi through fault mask", 8'b0000_1000, 1'b1, 1'b1, 1'b1, 3'd0);
    wr(1'b1, 2'd0, 32'd0);
    act_check("R9 nmi beats unmasked level 0", 8'b0000_1000, 1'b1, 1'b1, 1'b1, 3'd0);
  endtask

  task automatic t_timing;
    req_prio = '0;
    set_prio(6, 3'd5);
    @(negedge clk);
    req_pend = 8'b0100_0000;
    #1;
    check32("R11 no strobe before edge", {31'd0, act_strobe}, 32'd0);
    @(negedge clk);
    req_pend = '0;
    check32("R11 strobe after edge", {31'd0, act_strobe}, 32'd1);
    check32("R11 strobe idx", {29'd0, act_idx}, 32'd6);
    @(negedge clk);
    check32("R11 strobe drops with request", {31'd0, act_strobe}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_layout;
    t_priv;
    t_arbitrate;
    t_base;
    t_masks;
    t_timing;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule